// File: doc/BRIEF.md
# Eight-Line GPIO Port with Edge Request Generation

This block provides eight general-purpose lines that software can set, one by one, as inputs or as outputs. It also turns a chosen transition on any line into a one-clock interrupt request. It sits on a small register bus with a two-bit address, separate read and write strobes and byte-wide data. It holds three registers:

- a port data register;
- an edge-polarity register;
- a direction register.

The input pins pass through a two-flop synchronizer. The synchronized level is used both by port reads and by the edge logic.

For each line, the synchronized pin level is XORed with that line's polarity bit. The result feeds a single falling-transition detector. A polarity bit of 0 therefore reports high-to-low pin transitions, and a polarity bit of 1 reports low-to-high ones. The polarity bit sits inside the compared signal, so a write that changes it can create a qualifying transition by itself. The eight request pulses leave the block and go to a separate enable/pending stage.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is high and in the cycle after it falls, the data, polarity and direction registers read zero, `pin_oe` and `pin_out` are all zero, and `irq_pulse` is zero.
- R2: A write strobe at offset 0 (data), 1 (polarity) or 2 (direction) updates only that register on the same clock edge. A read at offset 1 or 2 returns the stored value on `bus_rdata` one cycle after the strobe. A read at offset 3 returns zero, and `bus_rdata` is zero in any cycle that follows a cycle without a read strobe.
- R3: `pin_oe[i]` equals direction bit i, where 1 means output and 0 means input. `pin_out[i]` equals data register bit i.
- R4: A read at offset 0 returns the stored data bit for each line whose direction bit is 1, and the synchronized pin level for each line whose direction bit is 0.
- R5: With polarity bit i at 0, a high-to-low change on `pin_in[i]` gives `irq_pulse[i]` high in the third cycle after the change, counting the synchronizer and the detector register.
- R6: With polarity bit i at 1, a low-to-high change on `pin_in[i]` gives a pulse with the same timing. A high-to-low change gives none.
- R7: Each request pulse lasts exactly one clock. The transition opposite to the selected one raises no request.
- R8: Writing polarity bit i raises `irq_pulse[i]` one cycle after the write edge when (pin XOR polarity) goes from 1 to 0. When that value goes from 0 to 1 there is no request.
- R9: Edge detection works on every line whatever its direction bit.
- R10: No request is produced in the first cycles after reset, even if pins are high while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin levels from the input buffers |
| pin_out | output | 8 | Levels to drive on output lines |
| pin_oe | output | 8 | Output enable per line |
| irq_pulse | output | 8 | One-clock request per line |

## Verification
The assertions assume the following about the inputs:
- Reset is high from time zero.
- The address is always a known value.
- The bus strobes are sampled only on rising edges.

The pulse-width property also relies on two further input conditions:
- A line's synchronized level cannot complete a qualifying transition two cycles in a row.
- A polarity write does not land in the cycle after a pin transition on the same line.

The stimulus keeps within these limits. It drives every input at falling edges, uses single-cycle strobes, and holds each pin pattern for at least four cycles before any pulse is checked. It also separates polarity writes from pin changes.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    SEL_DATA = 2'd0,
    SEL_EDGE = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  rdata
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] rd_mux;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      edge_q <= '0;
      dir_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_DATA: data_q <= wdata;
        SEL_EDGE: edge_q <= wdata;
        SEL_DIR:  dir_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: rd_mux = (data_q & dir_q) | (pin_sync & ~dir_q);
      SEL_EDGE: rd_mux = edge_q;
      SEL_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd ? rd_mux : '0;
  end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] edge_sel,
  output logic [WIDTH-1:0] irq
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic comb_lvl;
    logic prev_lvl;

    assign comb_lvl = level[i] ^ edge_sel[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_lvl <= 1'b0;
        irq[i]   <= 1'b0;
      end else begin
        prev_lvl <= comb_lvl;
        irq[i]   <= prev_lvl & ~comb_lvl;
      end
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  irq_pulse
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] edge_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .data_q   (pin_out),
    .edge_q   (edge_q),
    .dir_q    (pin_oe),
    .rdata    (bus_rdata)
  );

  gpio_edge_det #(.WIDTH(WIDTH)) u_det (
    .clk      (clk),
    .rst      (rst),
    .level    (pin_sync),
    .edge_sel (edge_q),
    .irq      (irq_pulse)
  );
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  irq_pulse
);
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2) |=> pin_oe == $past(bus_wdata)); // R3

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> pin_out == $past(bus_wdata)); // R3

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd2) |=> $stable(pin_oe)); // R2

  AST_UNUSED_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd3) |=> bus_rdata == '0); // R2

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R2

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=>
      (bus_rdata & $past(pin_oe)) == ($past(pin_out) & $past(pin_oe))); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |=> (irq_pulse & $past(irq_pulse)) == '0); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_pulse == '0); // R10
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq_pulse (irq_pulse)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;
  logic [7:0] irq_pulse;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pulse (irq_pulse)
  );

  // {direction, data, pin, expected port read}
  localparam logic [31:0] VEC [6] = '{
    32'hFF_A5_00_A5,
    32'h00_A5_3C_3C,
    32'hF0_5A_0F_5F,
    32'h0F_C3_A0_A3,
    32'hAA_FF_00_AA,
    32'h55_00_FF_AA
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // pin change at a falling edge; pulse expected after the third rising edge
  task automatic pin_step(input logic [7:0] p, input logic [7:0] exp, input string req);
    @(negedge clk);
    pin_in = p;
    @(negedge clk);
    @(negedge clk);
    check(irq_pulse, 8'h00, req);
    @(negedge clk);
    check(irq_pulse, exp, req);
    @(negedge clk);
    check(irq_pulse, 8'h00, req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    pin_in = 8'hFF;                       // pins high during reset (R10)
    repeat (3) @(negedge clk);
    check(pin_oe, 8'h00, "R1 oe in reset");
    check(pin_out, 8'h00, "R1 out in reset");
    check(irq_pulse, 8'h00, "R1 irq in reset");
    rst = 1'b0;
    @(negedge clk);
    check(irq_pulse, 8'h00, "R1 irq after reset");
    check(pin_oe, 8'h00, "R1 oe after reset");
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(irq_pulse, 8'h00, "R10 quiet after reset");
    end
    rd_reg(2'd1, rv); check(rv, 8'h00, "R1 polarity reg zero");
    rd_reg(2'd2, rv); check(rv, 8'h00, "R1 direction reg zero");

    // table walk: direction/data/pin mixes (R3, R4)
    for (int k = 0; k < 6; k++) begin
      wr_reg(2'd2, VEC[k][31:24]);
      wr_reg(2'd0, VEC[k][23:16]);
      pin_in = VEC[k][15:8];
      idle(4);
      check(pin_oe, VEC[k][31:24], "R3 oe");
      check(pin_out, VEC[k][23:16], "R3 out");
      rd_reg(2'd0, rv);
      check(rv, VEC[k][7:0], "R4 port read");
    end

    // register access (R2)
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd2, 8'h3C);
    rd_reg(2'd2, rv); check(rv, 8'h3C, "R2 direction readback");
    rd_reg(2'd3, rv); check(rv, 8'h00, "R2 unused offset");
    @(negedge clk); check(bus_rdata, 8'h00, "R2 idle read zero");
    wr_reg(2'd3, 8'hFF);
    check(pin_oe, 8'h3C, "R2 unused write ignored");
    rd_reg(2'd1, rv); check(rv, 8'h00, "R2 polarity untouched");
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'h00);
    pin_in = 8'hFF;
    idle(6);

    // falling edges with polarity 0 (R5, R7)
    pin_step(8'hFE, 8'h01, "R5 fall bit0");
    pin_step(8'hFF, 8'h00, "R7 rise ignored bit0");

    // polarity write triggers (R8): pin1 high, polarity 0->1 makes combined 1->0
    wr_reg(2'd1, 8'h02);
    check(irq_pulse, 8'h00, "R8 not before");
    @(negedge clk); check(irq_pulse, 8'h02, "R8 write trigger");
    @(negedge clk); check(irq_pulse, 8'h00, "R8 single pulse");

    // rising polarity (R6)
    pin_step(8'hFD, 8'h00, "R6 fall ignored bit1");
    pin_step(8'hFF, 8'h02, "R6 rise bit1");

    // polarity write back to 0 with pin high: combined 0->1, no request (R8)
    wr_reg(2'd1, 8'h00);
    @(negedge clk); check(irq_pulse, 8'h00, "R8 no trigger");
    @(negedge clk); check(irq_pulse, 8'h00, "R8 no trigger late");

    // output lines still detect (R9)
    wr_reg(2'd2, 8'hFF);
    idle(2);
    pin_step(8'h7F, 8'h80, "R9 output line edge");
    // several lines at once (R5)
    pin_step(8'h00, 8'h7F, "R5 multi-line fall");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule